// File: doc/BRIEF.md
# Keyboard Scan-Code Port Interface

This block sits between a keyboard front end and a processor's I/O bus. The keyboard side hands over one byte at a time: a strobe and a parallel code. Bit 7 of that code tells a press from a release, and bits 6:0 carry the scan code. The block latches the byte, raises interrupt request line 1 and holds the code until software acknowledges it. Software services interrupt type 9 and reads the code from the input port.

The processor sees four consecutive byte addresses starting at a parameterized base, 60H by default. They are the code input port, an output port, a general input port and a command register. Software acknowledges a code by writing bit 7 of the output port high and then low. The write that takes that bit from 1 to 0 drops the interrupt and reopens the keyboard-side ready handshake. A code offered while an earlier one is still unacknowledged is held off by that handshake, so a waiting code is never overwritten.

Top module: `kbd_scan_port`

## Requirements
- R1: After reset, pb_out is 00H, irq1 is 0 and kb_ready is 1, and reads of the code port, output port and command register all return 00H.
- R2: A byte on kb_code is captured at a clock edge where kb_valid and kb_ready are both 1. From then on, a read at offset 0 (address 60H by default) returns that byte unchanged: bit 7 is 0 for a press and 1 for a release, and bits 6:0 are the scan code.
- R3: irq1 goes high in the cycle after a capture and kb_ready goes low in that same cycle. Both hold these values until the code is acknowledged.
- R4: Only a write to offset 1 (61H) whose data bit 7 is 0 while pb_out bit 7 is 1 acknowledges the pending code, and it clears irq1 in the next cycle. Setting bit 7 does not acknowledge. Writing bit 7 as 0 while it is already 0 does not acknowledge either.
- R5: While a code is unacknowledged, kb_ready is 0 and kb_valid is ignored, so a read at offset 0 keeps returning the earlier code.
- R6: A write at offset 1 drives its data on pb_out from the next cycle, and a read at offset 1 returns the last written value.
- R7: A read at offset 2 (62H) returns the current value of pc_in.
- R8: A write at offset 3 (63H) is stored and read back at offset 3. It does not change pb_out, and offset 2 still reads pc_in afterwards.
- R9: An address outside the four-byte window reads 00H, and a write to it changes no register, including the acknowledge state.
- R10: When an acknowledging write and a kb_valid fall in the same cycle, the offered byte is not taken in that cycle. It is taken at the next edge if kb_valid is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_code | input | 8 | Code byte from the keyboard side |
| kb_valid | input | 1 | Keyboard offers kb_code |
| kb_ready | output | 1 | Block can accept a code |
| irq1 | output | 1 | Interrupt request line 1 (type 9) |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from io_addr |
| pc_in | input | 8 | General input port pins |
| pb_out | output | 8 | Output port pins, bit 7 is the acknowledge line |

## Verification
The clash that matters is an acknowledging write (the falling edge of bit 7 at offset 1) in the same cycle as a new kb_valid. The bench provokes it by raising the strobe with a fresh byte in the very cycle that software clears bit 7, and it keeps the strobe high for one more cycle. After the first edge it expects irq1 low, kb_ready high and the old code still readable. After the second edge it expects irq1 high again and the new byte at offset 0.

// File: rtl/kbd_scan_port.sv
module kbd_scan_port #(
  parameter int ADDR_W = 16,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     kb_code,
  input  logic              kb_valid,
  output logic              kb_ready,
  output logic              irq1,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [DW-1:0]     pc_in,
  output logic [DW-1:0]     pb_out
);
  localparam int MSB = DW - 1;
  localparam logic [ADDR_W-1:0] ADDR_B = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_K = BASE + ADDR_W'(3);

  logic [DW-1:0] code_q, pb_q, cmd_q;
  logic          full_q;

  wire       hit   = io_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2];
  wire [1:0] off   = io_addr[1:0];
  wire       wr_b  = io_wr && hit && off == 2'd1;
  wire       wr_k  = io_wr && hit && off == 2'd3;
  wire       ack   = wr_b && pb_q[MSB] && !io_wdata[MSB];
  wire       take  = kb_valid && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      pb_q   <= '0;
      cmd_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take) code_q <= kb_code;
      if (take) full_q <= 1'b1;
      else if (ack) full_q <= 1'b0;
      if (wr_b) pb_q <= io_wdata;
      if (wr_k) cmd_q <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (hit) begin
      case (off)
        2'd0: io_rdata = code_q;
        2'd1: io_rdata = pb_q;
        2'd2: io_rdata = pc_in;
        default: io_rdata = cmd_q;
      endcase
    end
  end

  assign kb_ready = !full_q;
  assign irq1     = full_q;
  assign pb_out   = pb_q;

  a_r3_irq_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1) |-> $past(kb_valid));

  a_r4_irq_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq1) |-> ($past(io_wr) && $past(io_addr) == ADDR_B
                     && !$past(io_wdata[MSB]) && $past(pb_out[MSB])));

  a_r5_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !kb_ready |=> $stable(code_q));

  a_r6_pb_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_B) |=> pb_out == $past(io_wdata));

  a_r8_cmd_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_K) |=> $stable(pb_out));
endmodule

// File: tb/sim_kbd_scan_port.sv
module sim_kbd_scan_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  kb_code = 0;
  logic        kb_valid = 0;
  logic        kb_ready, irq1;
  logic [15:0] io_addr = 0;
  logic        io_wr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata, pb_out;
  logic [7:0]  pc_in = 0;

  int checks = 0, fails = 0;
  logic [7:0] e_code = 0, e_pb = 0, e_cmd = 0;

  always #10 clk = ~clk;

  kbd_scan_port u0 (.clk(clk), .rst_n(rst_n), .kb_code(kb_code), .kb_valid(kb_valid),
    .kb_ready(kb_ready), .irq1(irq1), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pc_in(pc_in), .pb_out(pb_out));

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (a[15:2] != 14'h0018) return 8'h00;
    case (a[1:0])
      2'd0: return e_code;
      2'd1: return e_pb;
      2'd2: return pc_in;
      default: return e_cmd;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [15:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp_rd(a));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic offer(input logic [7:0] c);
    @(negedge clk);
    kb_code = c; kb_valid = 1;
    @(negedge clk);
    kb_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] c, p, d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 irq1", {7'd0, irq1}, 8'h00);
    chk("R1 kb_ready", {7'd0, kb_ready}, 8'h01);
    chk_rd("R1 read A", 16'h0060);
    chk_rd("R1 read B", 16'h0061);
    chk_rd("R1 read cmd", 16'h0063);

    // R2 release code, R3 irq
    offer(8'h9E); e_code = 8'h9E;
    chk_rd("R2 release code", 16'h0060);
    chk("R3 irq high", {7'd0, irq1}, 8'h01);
    chk("R3 ready low", {7'd0, kb_ready}, 8'h00);
    // R4 clearing bit 7 while already 0 is no ack
    wr(16'h0061, 8'h00); e_pb = 8'h00;
    chk("R4 no ack when bit7 rests", {7'd0, irq1}, 8'h01);
    // R9 out-of-window writes, including an apparent ack
    wr(16'h0065, 8'h80); wr(16'h0065, 8'h00);
    chk("R9 stray ack ignored", {7'd0, irq1}, 8'h01);
    chk_rd("R9 read outside", 16'h0064);
    chk_rd("R9 read below", 16'h005F);
    chk_rd("R9 pb unchanged", 16'h0061);
    // R4 set then clear
    wr(16'h0061, 8'h80); e_pb = 8'h80;
    chk("R4 set alone no ack", {7'd0, irq1}, 8'h01);
    wr(16'h0061, 8'h00); e_pb = 8'h00;
    chk("R4 ack clears irq", {7'd0, irq1}, 8'h00);
    chk("R4 ready back", {7'd0, kb_ready}, 8'h01);

    // R10 ack and strobe in the same cycle
    offer(8'h1C); e_code = 8'h1C;
    wr(16'h0061, 8'h80); e_pb = 8'h80;
    @(negedge clk);
    io_addr = 16'h0061; io_wdata = 8'h00; io_wr = 1;
    kb_code = 8'h2A; kb_valid = 1;
    @(negedge clk);
    io_wr = 0; e_pb = 8'h00;
    chk("R10 irq cleared", {7'd0, irq1}, 8'h00);
    chk("R10 ready", {7'd0, kb_ready}, 8'h01);
    chk_rd("R10 old code kept", 16'h0060);
    @(negedge clk);
    kb_valid = 0; e_code = 8'h2A;
    chk("R10 irq again", {7'd0, irq1}, 8'h01);
    chk_rd("R10 new code", 16'h0060);
    wr(16'h0061, 8'h80); wr(16'h0061, 8'h00); e_pb = 8'h00;

    // random traffic
    for (int i = 0; i < 40; i++) begin
      c = 8'($urandom); p = 8'($urandom);
      pc_in = p;
      offer(c); e_code = c;
      chk_rd("R2 random code", 16'h0060);
      chk("R3 irq random", {7'd0, irq1}, 8'h01);
      if ($urandom % 2) begin
        offer(~c);
        chk_rd("R5 intruder ignored", 16'h0060);
        chk("R5 ready low", {7'd0, kb_ready}, 8'h00);
      end
      if ($urandom % 2) begin
        d = 8'($urandom);
        wr(16'h0063, d); e_cmd = d;
        chk_rd("R8 cmd readback", 16'h0063);
        chk("R8 pb_out kept", pb_out, e_pb);
        chk_rd("R8 port C still input", 16'h0062);
      end
      d = 8'($urandom) | 8'h80;
      wr(16'h0061, d); e_pb = d;
      chk("R6 pb_out", pb_out, e_pb);
      chk_rd("R6 pb readback", 16'h0061);
      chk("R4 irq held after set", {7'd0, irq1}, 8'h01);
      d = 8'($urandom) & 8'h7F;
      wr(16'h0061, d); e_pb = d;
      chk("R4 irq cleared", {7'd0, irq1}, 8'h00);
      chk_rd("R7 port C", 16'h0062);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule